// File: doc/BRIEF.md
# Paired Copy Descriptor Builder

This block turns one memory-to-memory copy request into a pair of 128-bit ring descriptors. The first is a transmit descriptor that tells the copy engine where to read the source. The second is a receive descriptor that tells it where to write the destination. Both descriptors go into the same slot index of two descriptor rings that belong to one queue. The request carries:

- a source address and a destination address;
- a byte size;
- a 2-bit ring phase;
- an ordering (barrier) mode;
- a destination-interrupt flag;
- a hardware generation code.

Requests arrive on a valid/ready handshake. The block checks each request when it accepts it. If the request is bad, the block writes nothing, rings no doorbell and pulses `error`. If the request is good, the block writes both descriptors in one cycle. It then rings the receive doorbell, and one cycle later the transmit doorbell together with a `done` pulse. Each ring keeps its own write pointer, which advances one slot per copy and wraps at `RING_DEPTH`.

Descriptor layout is little-endian over 128 bits:
- bits 31:0 are the control word (word0);
- bits 63:32 are the meta word (word1);
- bits 127:64 are the 64-bit address.

Top module: `copy_desc_pair_builder`

## Requirements
- R1: `req_ready` is 1 only while the block is idle. It drops in the cycle after a request is accepted and returns after `done` or `error`.
- R2: The transmit descriptor holds the source address in bits 127:64. The receive descriptor holds the destination address in bits 127:64 and all zeros in word1 (bits 63:32).
- R3: In word0 of both descriptors:
  - bits 15:0 hold the length code;
  - bits 25:24 hold `req_phase`;
  - bit 26 (FIRST) and bit 27 (LAST) are both 1;
  - bits 22:16 are 0.
- R4: A size of 1 to 65535 is placed in the length field as is. A size of 65536 is encoded as length 0.
- R5: A size of 0, or a size above 65536, is rejected.
- R6: Transmit word1 is 32'h0108_0003 unless barrier mode 2 is requested.
- R7: Barrier mode 0 sets no ordering bit. Mode 1 sets bit 30 of transmit word0. Mode 2 sets bit 26 of transmit word1. Mode 3 sets bit 29 of receive word0. No other ordering bit is set in either descriptor.
- R8: A barrier mode of 4 to 7 is rejected.
- R9: Barrier mode 3 is rejected when `req_gen` is below 3. It is accepted for generations 3 and 4.
- R10: When `req_dst_irq` is 1, bit 28 is set in receive word0. Bit 28 of transmit word0 is always 0.
- R11: On an accepted request, `tx_wr_en` and `rx_wr_en` are both high for exactly one cycle, at the same slot index. On a rejected request, `error` pulses for one cycle and there is no write, no doorbell and no pointer movement.
- R12: `rx_doorbell` pulses in the cycle after the write. `tx_doorbell` and `done` pulse together in the cycle after that.
- R13: The write pointers start at 0 after reset. They advance by one after each accepted copy and wrap from `RING_DEPTH-1` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Block can accept a request |
| req_src_addr | input | 64 | Source address |
| req_dst_addr | input | 64 | Destination address |
| req_size | input | 17 | Byte count, valid 1..65536 |
| req_phase | input | 2 | Ring phase |
| req_barrier | input | 3 | Ordering mode, 0..3 valid |
| req_dst_irq | input | 1 | Request an interrupt on destination completion |
| req_gen | input | 3 | Hardware generation code |
| tx_wr_en | output | 1 | Write strobe for the transmit ring |
| tx_wr_idx | output | $clog2(RING_DEPTH) | Transmit ring slot |
| tx_wr_data | output | 128 | Transmit descriptor |
| rx_wr_en | output | 1 | Write strobe for the receive ring |
| rx_wr_idx | output | $clog2(RING_DEPTH) | Receive ring slot |
| rx_wr_data | output | 128 | Receive descriptor |
| rx_doorbell | output | 1 | Receive ring doorbell pulse |
| tx_doorbell | output | 1 | Transmit ring doorbell pulse |
| done | output | 1 | Copy pair published |
| error | output | 1 | Request rejected |

## Verification
The bench sweeps every combination of:
- all eight barrier codes;
- generation codes 2, 3 and 4;
- both interrupt settings;
- a set of sizes that includes 0, 1, 65535, 65536 and values above 65536.

The phase rotates and the addresses change with every request.

The barrier sweep shows which of the three ordering locations each mode reaches, and that the mode touches no other bit. Crossing the barrier codes with the generations separates the generation gate from the invalid-mode rejection. The size sweep separates literal encoding, the zero-for-64-KiB encoding and both rejection edges. Long runs of mixed accepted and rejected requests show that the pointers step only on success and wrap at the ring depth.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
    localparam int ADDR_W = 64;
    localparam int SIZE_W = 17;
    localparam int LEN_W  = 16;
    localparam int WORD_W = 32;
    localparam int DESC_W = 2 * WORD_W + ADDR_W;
    localparam int MODE_W = 3;
    localparam int GEN_W  = 3;

    // control word bit positions
    localparam int PH_LSB  = 24;
    localparam int F_FIRST = 26;
    localparam int F_LAST  = 27;
    localparam int F_IRQ   = 28;
    localparam int F_SOW   = 29;
    localparam int F_DMB   = 30;
    // meta word bit position
    localparam int M_WBAR  = 26;

    localparam logic [WORD_W-1:0] META_BASE = 32'h0108_0003;
    localparam logic [SIZE_W-1:0] SIZE_MAX  = SIZE_W'(1 << LEN_W);
    localparam logic [GEN_W-1:0]  GEN_SOW   = GEN_W'(3);

    localparam logic [MODE_W-1:0] MODE_NONE = MODE_W'(0);
    localparam logic [MODE_W-1:0] MODE_DMB  = MODE_W'(1);
    localparam logic [MODE_W-1:0] MODE_WBAR = MODE_W'(2);
    localparam logic [MODE_W-1:0] MODE_SOW  = MODE_W'(3);

    typedef enum logic [2:0] {
        S_IDLE, S_WRITE, S_RX_BELL, S_TX_BELL, S_FAIL
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] meta;
        logic [WORD_W-1:0] ctrl;
    } desc_t;
endpackage

// File: rtl/cdp_req_check.sv
module cdp_req_check
    import cdp_pkg::*;
(
    input  logic [SIZE_W-1:0] size_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [GEN_W-1:0]  gen_i,
    output logic              ok_o,
    output logic [LEN_W-1:0]  len_o
);
    logic size_bad, mode_bad, gen_bad;

    always_comb begin
        size_bad = (size_i == '0) || (size_i > SIZE_MAX);
        mode_bad = (mode_i > MODE_SOW);
        gen_bad  = (mode_i == MODE_SOW) && (gen_i < GEN_SOW);
        ok_o     = !(size_bad || mode_bad || gen_bad);
        len_o    = (size_i == SIZE_MAX) ? '0 : size_i[LEN_W-1:0];
    end
endmodule

// File: rtl/cdp_ctrl_enc.sv
module cdp_ctrl_enc
    import cdp_pkg::*;
(
    input  logic [LEN_W-1:0]  len_i,
    input  logic [1:0]        phase_i,
    input  logic              dmb_i,
    input  logic              sow_i,
    input  logic              irq_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb begin
        word_o              = '0;
        word_o[LEN_W-1:0]   = len_i;
        word_o[PH_LSB +: 2] = phase_i;
        word_o[F_FIRST]     = 1'b1;
        word_o[F_LAST]      = 1'b1;
        word_o[F_IRQ]       = irq_i;
        word_o[F_SOW]       = sow_i;
        word_o[F_DMB]       = dmb_i;
    end
endmodule

// File: rtl/cdp_ring_ptr.sv
module cdp_ring_ptr #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [IDX_W-1:0] ptr_o
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv_i) ptr_d = (ptr_q == TOP) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/copy_desc_pair_builder.sv
module copy_desc_pair_builder
    import cdp_pkg::*;
#(
    parameter int RING_DEPTH = 8,
    localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_src_addr,
    input  logic [63:0]       req_dst_addr,
    input  logic [16:0]       req_size,
    input  logic [1:0]        req_phase,
    input  logic [2:0]        req_barrier,
    input  logic              req_dst_irq,
    input  logic [2:0]        req_gen,
    output logic              tx_wr_en,
    output logic [IDX_W-1:0]  tx_wr_idx,
    output logic [127:0]      tx_wr_data,
    output logic              rx_wr_en,
    output logic [IDX_W-1:0]  rx_wr_idx,
    output logic [127:0]      rx_wr_data,
    output logic              rx_doorbell,
    output logic              tx_doorbell,
    output logic              done,
    output logic              error
);
    typedef struct packed {
        state_e state;
        desc_t  tx;
        desc_t  rx;
    } core_t;

    core_t cur_q, nxt_d;

    logic             req_ok;
    logic [LEN_W-1:0] len_code;
    logic [WORD_W-1:0] ctrl_w [2];
    logic [WORD_W-1:0] tx_meta;
    logic             advance;
    logic [IDX_W-1:0] ptr_w [2];

    cdp_req_check u_check (
        .size_i (req_size),
        .mode_i (req_barrier),
        .gen_i  (req_gen),
        .ok_o   (req_ok),
        .len_o  (len_code)
    );

    // index 0 builds the transmit control word, index 1 the receive one
    for (genvar g = 0; g < 2; g++) begin : g_enc
        logic dmb_b, sow_b, irq_b;
        if (g == 0) begin : g_tx
            assign dmb_b = (req_barrier == MODE_DMB);
            assign sow_b = 1'b0;
            assign irq_b = 1'b0;
        end else begin : g_rx
            assign dmb_b = 1'b0;
            assign sow_b = (req_barrier == MODE_SOW);
            assign irq_b = req_dst_irq;
        end
        cdp_ctrl_enc u_enc (
            .len_i   (len_code),
            .phase_i (req_phase),
            .dmb_i   (dmb_b),
            .sow_i   (sow_b),
            .irq_i   (irq_b),
            .word_o  (ctrl_w[g])
        );
        cdp_ring_ptr #(.DEPTH(RING_DEPTH)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .adv_i (advance),
            .ptr_o (ptr_w[g])
        );
    end

    always_comb begin
        tx_meta         = META_BASE;
        tx_meta[M_WBAR] = (req_barrier == MODE_WBAR);
    end

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_ok) begin
                        nxt_d.state   = S_WRITE;
                        nxt_d.tx.addr = req_src_addr;
                        nxt_d.tx.meta = tx_meta;
                        nxt_d.tx.ctrl = ctrl_w[0];
                        nxt_d.rx.addr = req_dst_addr;
                        nxt_d.rx.meta = '0;
                        nxt_d.rx.ctrl = ctrl_w[1];
                    end else begin
                        nxt_d.state = S_FAIL;
                    end
                end
            end
            S_WRITE:   nxt_d.state = S_RX_BELL;
            S_RX_BELL: nxt_d.state = S_TX_BELL;
            S_TX_BELL: nxt_d.state = S_IDLE;
            S_FAIL:    nxt_d.state = S_IDLE;
            default:   nxt_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= S_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign advance     = (cur_q.state == S_WRITE);
    assign req_ready   = (cur_q.state == S_IDLE);
    assign tx_wr_en    = advance;
    assign rx_wr_en    = advance;
    assign tx_wr_idx   = ptr_w[0];
    assign rx_wr_idx   = ptr_w[1];
    assign tx_wr_data  = cur_q.tx;
    assign rx_wr_data  = cur_q.rx;
    assign rx_doorbell = (cur_q.state == S_RX_BELL);
    assign tx_doorbell = (cur_q.state == S_TX_BELL);
    assign done        = (cur_q.state == S_TX_BELL);
    assign error       = (cur_q.state == S_FAIL);
endmodule

// File: rtl/cdp_checker.sv
module cdp_checker #(
    parameter int RING_DEPTH = 8,
    localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             tx_wr_en,
    input logic [IDX_W-1:0] tx_wr_idx,
    input logic [127:0]     tx_wr_data,
    input logic             rx_wr_en,
    input logic [IDX_W-1:0] rx_wr_idx,
    input logic [127:0]     rx_wr_data,
    input logic             rx_doorbell,
    input logic             tx_doorbell,
    input logic             done,
    input logic             error
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(RING_DEPTH - 1);

    // R1
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R11
    pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_en |-> rx_wr_en && (tx_wr_idx == rx_wr_idx));

    // R11
    fail_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !tx_wr_en && !rx_wr_en && !rx_doorbell && !tx_doorbell && !done);

    // R12
    rx_bell_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr_en |=> rx_doorbell && !tx_doorbell && !rx_wr_en);

    // R12
    tx_bell_after_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_doorbell |=> tx_doorbell && done && !rx_doorbell);

    // R13
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_en |=> tx_wr_idx == (($past(tx_wr_idx) == TOP) ? '0 : $past(tx_wr_idx) + 1'b1));

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_en |-> (tx_wr_data[22:16] == '0) && (rx_wr_data[22:16] == '0));

    // R3
    first_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_en |-> (&tx_wr_data[27:26]) && (&rx_wr_data[27:26]));

    // R2
    rx_meta_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr_en |-> rx_wr_data[63:32] == '0);
endmodule

bind copy_desc_pair_builder cdp_checker #(.RING_DEPTH(RING_DEPTH)) u_cdp_checker (.*);

// File: tb/tb_copy_desc_pair_builder.sv
module tb_copy_desc_pair_builder;
    localparam int DEPTH = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [63:0] req_src_addr = '0, req_dst_addr = '0;
    logic [16:0] req_size = '0;
    logic [1:0]  req_phase = '0;
    logic [2:0]  req_barrier = '0;
    logic        req_dst_irq = 1'b0;
    logic [2:0]  req_gen = '0;
    logic tx_wr_en, rx_wr_en, rx_doorbell, tx_doorbell, done, error;
    logic [IW-1:0] tx_wr_idx, rx_wr_idx;
    logic [127:0] tx_wr_data, rx_wr_data;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ptr = 0;

    always #5 clk = ~clk;

    copy_desc_pair_builder #(.RING_DEPTH(DEPTH)) dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input int size, input int mode, input int gen, input int irq,
                           input int phase, input logic [63:0] src, input logic [63:0] dst);
        bit bad;
        logic [31:0] w0t, w0r, mt;
        logic [127:0] et, er;
        int len;
        bad = (size == 0) || (size > 65536) || (mode > 3) || (mode == 3 && gen < 3);
        len = size % 65536;
        w0t = 32'h0C00_0000 + 32'(phase) * 32'h0100_0000 + 32'(len);
        w0r = w0t;
        if (mode == 1) w0t = w0t + 32'h4000_0000;
        if (mode == 3) w0r = w0r + 32'h2000_0000;
        if (irq != 0)  w0r = w0r + 32'h1000_0000;
        mt = 32'h0108_0003 + ((mode == 2) ? 32'h0400_0000 : 32'h0);
        et = {src, mt, w0t};
        er = {dst, 32'h0, w0r};

        @(negedge clk);
        req_valid = 1'b1; req_size = 17'(size); req_barrier = 3'(mode);
        req_gen = 3'(gen); req_dst_irq = 1'(irq); req_phase = 2'(phase);
        req_src_addr = src; req_dst_addr = dst;
        chk(req_ready == 1'b1, "R1 ready idle", 128'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1 busy after accept", 128'(req_ready), 0);
        if (bad) begin
            chk(error && !tx_wr_en && !rx_wr_en, "R5/R8/R9 R11 reject",
                {error, tx_wr_en, rx_wr_en}, 3'b100);
            @(negedge clk);
            chk(!error && !rx_doorbell && !tx_doorbell && !done && req_ready,
                "R11 reject silent", {error, rx_doorbell, tx_doorbell, done, req_ready}, 5'b00001);
        end else begin
            chk(tx_wr_en && rx_wr_en && !error, "R11 write both", {tx_wr_en, rx_wr_en, error}, 3'b110);
            chk(32'(tx_wr_idx) == exp_ptr && 32'(rx_wr_idx) == exp_ptr, "R13 slot index",
                {tx_wr_idx, rx_wr_idx}, {2'(exp_ptr), 2'(exp_ptr)});
            chk(tx_wr_data[15:0] == er[15:0], "R4 length code", tx_wr_data[15:0], er[15:0]);
            chk(tx_wr_data[31:0] == et[31:0], "R3 R7 tx word0", tx_wr_data[31:0], et[31:0]);
            chk(tx_wr_data[63:32] == et[63:32], "R6 R7 tx meta", tx_wr_data[63:32], et[63:32]);
            chk(tx_wr_data[127:64] == src, "R2 tx addr", tx_wr_data[127:64], src);
            chk(rx_wr_data == er, "R2 R3 R7 R10 rx desc", rx_wr_data, er);
            chk(!rx_doorbell && !tx_doorbell, "R12 no bell at write", {rx_doorbell, tx_doorbell}, 0);
            @(negedge clk);
            chk(rx_doorbell && !tx_doorbell && !done && !tx_wr_en, "R12 rx bell first",
                {rx_doorbell, tx_doorbell, done, tx_wr_en}, 4'b1000);
            @(negedge clk);
            chk(!rx_doorbell && tx_doorbell && done, "R12 tx bell with done",
                {rx_doorbell, tx_doorbell, done}, 3'b011);
            exp_ptr = (exp_ptr + 1) % DEPTH;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", n_chk, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int sizes[8] = '{1, 255, 4096, 65535, 65536, 0, 65537, 131071};
        int k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R13 reset state
        chk(req_ready && !tx_wr_en && !rx_wr_en && !done && !error && !rx_doorbell && !tx_doorbell,
            "R1 reset outputs", {req_ready, tx_wr_en, rx_wr_en, done, error, rx_doorbell, tx_doorbell}, 7'h40);
        chk(tx_wr_idx == '0 && rx_wr_idx == '0, "R13 reset ptr", {tx_wr_idx, rx_wr_idx}, 0);
        for (int m = 0; m < 8; m++)
            for (int g = 2; g <= 4; g++)
                for (int i = 0; i < 2; i++)
                    for (int s = 0; s < 8; s++) begin
                        logic [63:0] a;
                        a = 64'h0123_4567_0000_0000 + 64'(k) * 64'h1_0000_0010;
                        run_one(sizes[s], m, g, i, k % 4, a, ~a);
                        k++;
                    end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule